// File: doc/BRIEF.md
# Seconds/Minutes Watchdog Timer Core

This block is a watchdog counter that lives in a byte-wide configuration register space. Software programs a count value, a time unit and a set of output routes. The counter then runs down once per second or once per minute, derived from a one-cycle tick input through a prescaler. When it reaches zero it raises a sticky expiry flag and drives a fixed-length pulse on each routed timeout output. Software can also force an expiry at once.

Activity on selected peripherals keeps the system alive. An infrared-controller interrupt, a mouse interrupt, a keyboard interrupt and a joystick-port read strobe can each reload the counter, and each has its own enable bit. A reload lands a fixed number of clock cycles after the event. A zero count value parks the counter, so the watchdog is off. With all output routes cleared the block is in a test mode: an expiry only sets the flag, which software reads and clears without resetting the system. The count width is a parameter; an 8-bit build ignores the high value byte.

Top module: `wdt_core`

## Requirements
- R1: After reset the expiry flag and all timeout outputs are 0, irq_route_o is 0, the count value is 0 and no expiry occurs without a write.
- R2: Only writes with wr_idx_i equal to 0x71 (control), 0x72 (config), 0x73 (value low byte) or 0x74 (value high byte) have any effect; writes to other indices are ignored.
- R3: With config bit 7 set (seconds unit) and tick_i high every cycle, the flag sets V*TICKS_PER_SEC cycles after the edge that wrote the last value byte V.
- R4: With config bit 7 clear (minutes unit), the flag sets V*TICKS_PER_SEC*SECS_PER_MIN tick cycles after that edge.
- R5: A count value of 0 stops the counter; writing 0 while it runs cancels the pending expiry.
- R6: An event reloads the counter from the stored value and restarts the prescaler RELOAD_DLY cycles after the edge that sampled it, when its control enable bit is set: bit 7 infrared interrupt, bit 6 mouse interrupt, bit 5 keyboard interrupt, bit 4 joystick read.
- R7: An event whose control enable bit is clear has no effect on the countdown.
- R8: Writing the control register with bit 1 set sets the flag at that write's edge and stops the counter.
- R9: The flag (control bit 0) stays set until a control write with bit 0 equal to 0; a control write with bit 0 equal to 1 leaves it set.
- R10: On expiry each timeout output is high for PULSE_LEN cycles starting at the edge the flag sets: kbd_rst_o when config bit 6 is set, wdt_irq_o when config bit 5 is set, pwr_fail_o when config bit 4 is set; irq_route_o always shows config bits 3:0.
- R11: With config bits 6, 5 and 4 clear, an expiry sets only the flag and all timeout outputs stay 0.
- R12: The count value is 16 bits, with the high byte at index 0x74; a value of 257 expires after 257 units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 8 | Register index of the write |
| wr_data_i | input | 8 | Register write data |
| tick_i | input | 1 | One-cycle time base tick for the prescaler |
| ir_irq_i | input | 1 | Infrared-controller interrupt event |
| mouse_irq_i | input | 1 | Mouse interrupt event |
| kbd_irq_i | input | 1 | Keyboard interrupt event |
| joy_rd_i | input | 1 | Joystick-port read strobe |
| expired_o | output | 1 | Sticky expiry flag |
| kbd_rst_o | output | 1 | Timeout pulse to the keyboard-controller reset |
| pwr_fail_o | output | 1 | Timeout pulse that drops power-good |
| wdt_irq_o | output | 1 | Timeout pulse to the interrupt router |
| irq_route_o | output | 4 | Interrupt routing select from the config register |

## Verification
A value write loads the counter at its own edge, so the flag is due exactly V*TICKS_PER_SEC edges later in seconds mode and V*TICKS_PER_SEC*SECS_PER_MIN in minutes mode; an enabled event adds RELOAD_DLY edges from the edge that sampled it, and a forced expiry shows the flag at the write's edge. The bench drives every input on the falling clock edge and counts falling edges from the stimulus until the flag appears, comparing that count against the arithmetic value. The timeout pulses start on the same edge as the flag, so the bench checks the outputs at the first falling edge that shows the flag and then counts how many falling edges each stays high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] IDX_CTRL = 8'h71;
  localparam logic [7:0] IDX_CFG  = 8'h72;
  localparam logic [7:0] IDX_VLO  = 8'h73;
  localparam logic [7:0] IDX_VHI  = 8'h74;

  // control bits
  localparam int CTL_FORCE = 1;
  localparam int CTL_FLAG  = 0;
  // config bits
  localparam int CFG_SEC  = 7;
  localparam int CFG_KRST = 6;
  localparam int CFG_IRQ  = 5;
  localparam int CFG_PWR  = 4;

  typedef struct packed {
    logic ir;
    logic mouse;
    logic kbd;
    logic joy;
  } src_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_idx_i,
  input  logic [7:0]       wr_data_i,
  output src_t             src_en_o,
  output logic [7:0]       cfg_o,
  output logic             force_o,
  output logic             flag_clr_o,
  output logic [CNT_W-1:0] value_o,
  output logic             value_wr_o
);
  localparam bit HAS_HI = CNT_W > 8;

  logic wr_ctrl, wr_cfg, wr_lo, wr_hi;
  logic [7:0] lo_q, lo_nxt;
  src_t en_q;
  logic [7:0] cfg_q;

  assign wr_ctrl = wr_en_i && wr_idx_i == IDX_CTRL;
  assign wr_cfg  = wr_en_i && wr_idx_i == IDX_CFG;
  assign wr_lo   = wr_en_i && wr_idx_i == IDX_VLO;
  assign wr_hi   = wr_en_i && wr_idx_i == IDX_VHI && HAS_HI;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      cfg_q <= '0;
      lo_q  <= '0;
    end else begin
      if (wr_ctrl) en_q <= src_t'(wr_data_i[7:4]);
      if (wr_cfg)  cfg_q <= wr_data_i;
      if (wr_lo)   lo_q <= wr_data_i;
    end
  end

  assign lo_nxt = wr_lo ? wr_data_i : lo_q;

  // value_o is the value as it stands after this edge
  generate
    if (HAS_HI) begin : g_wide
      logic [CNT_W-9:0] hi_q, hi_nxt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    hi_q <= '0;
        else if (wr_hi) hi_q <= wr_data_i[CNT_W-9:0];
      end
      assign hi_nxt  = wr_hi ? wr_data_i[CNT_W-9:0] : hi_q;
      assign value_o = {hi_nxt, lo_nxt};
    end else begin : g_narrow
      assign value_o = lo_nxt[CNT_W-1:0];
    end
  endgenerate

  assign src_en_o   = en_q;
  assign cfg_o      = cfg_q;
  assign force_o    = wr_ctrl && wr_data_i[CTL_FORCE];
  assign flag_clr_o = wr_ctrl && !wr_data_i[CTL_FLAG];
  assign value_wr_o = wr_lo || wr_hi;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  logic sec_mode_i,
  output logic unit_stb_o
);
  localparam int SW = TICKS_PER_SEC > 1 ? $clog2(TICKS_PER_SEC) : 1;
  localparam int MW = SECS_PER_MIN > 1 ? $clog2(SECS_PER_MIN) : 1;

  logic [SW-1:0] sec_q;
  logic [MW-1:0] min_q;
  logic sec_stb, min_stb;

  assign sec_stb = tick_i && sec_q == SW'(TICKS_PER_SEC - 1);
  assign min_stb = sec_stb && min_q == MW'(SECS_PER_MIN - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (restart_i) begin
      sec_q <= '0;
      min_q <= '0;
    end else if (tick_i) begin
      if (sec_stb) begin
        sec_q <= '0;
        min_q <= min_stb ? '0 : min_q + 1'b1;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end
  end

  assign unit_stb_o = sec_mode_i ? sec_stb : min_stb;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W      = 16,
  parameter int RELOAD_DLY = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] value_i,
  input  logic             value_wr_i,
  input  logic             kick_i,
  input  logic             force_i,
  input  logic             unit_stb_i,
  output logic             restart_o,
  output logic             expire_o
);
  localparam int PW = $clog2(RELOAD_DLY + 1);

  logic [PW-1:0]    pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic reload, load;

  assign reload    = pend_q == PW'(1);
  assign load      = value_wr_i || reload;
  assign restart_o = load;
  assign expire_o  = force_i || (!load && unit_stb_i && cnt_q == CNT_W'(1));

  // keepalive lands RELOAD_DLY cycles after the sampled event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pend_q <= '0;
    else if (kick_i)         pend_q <= PW'(RELOAD_DLY);
    else if (pend_q != '0)   pend_q <= pend_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (force_i)                     cnt_q <= '0;
    else if (load)                        cnt_q <= value_i;
    else if (cnt_q != '0 && unit_stb_i)   cnt_q <= cnt_q - 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) != '0 && !$past(load) && !$past(force_i)) |->
      (cnt_q == ($past(unit_stb_i) ? $past(cnt_q) - 1'b1 : $past(cnt_q))));

  // R6
  cnt_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > $past(cnt_q)) |-> $past(load));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o
);
  localparam int LW = $clog2(PULSE_LEN + 1);
  logic [LW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           len_q <= '0;
    else if (start_i)      len_q <= LW'(PULSE_LEN);
    else if (len_q != '0)  len_q <= len_q - 1'b1;
  end

  assign active_o = len_q != '0;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int TICKS_PER_SEC = 1000,
  parameter int SECS_PER_MIN  = 60,
  parameter int RELOAD_DLY    = 8,
  parameter int PULSE_LEN     = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic       tick_i,
  input  logic       ir_irq_i,
  input  logic       mouse_irq_i,
  input  logic       kbd_irq_i,
  input  logic       joy_rd_i,
  output logic       expired_o,
  output logic       kbd_rst_o,
  output logic       pwr_fail_o,
  output logic       wdt_irq_o,
  output logic [3:0] irq_route_o
);
  src_t src_en, ev;
  logic [7:0] cfg;
  logic force_stb, flag_clr, value_wr, restart, unit_stb, expire, kick, pulse_act;
  logic [CNT_W-1:0] value;
  logic flag_q;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i,
    .src_en_o(src_en), .cfg_o(cfg), .force_o(force_stb),
    .flag_clr_o(flag_clr), .value_o(value), .value_wr_o(value_wr)
  );

  wdt_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECS_PER_MIN(SECS_PER_MIN)) u_presc (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i,
    .sec_mode_i(cfg[CFG_SEC]), .unit_stb_o(unit_stb)
  );

  assign ev   = '{ir: ir_irq_i, mouse: mouse_irq_i, kbd: kbd_irq_i, joy: joy_rd_i};
  assign kick = |(ev & src_en);

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_DLY(RELOAD_DLY)) u_cnt (
    .clk_i, .rst_ni, .value_i(value), .value_wr_i(value_wr), .kick_i(kick),
    .force_i(force_stb), .unit_stb_i(unit_stb), .restart_o(restart), .expire_o(expire)
  );

  wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i, .rst_ni, .start_i(expire), .active_o(pulse_act)
  );

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign expired_o   = flag_q;
  assign kbd_rst_o   = pulse_act && cfg[CFG_KRST];
  assign pwr_fail_o  = pulse_act && cfg[CFG_PWR];
  assign wdt_irq_o   = pulse_act && cfg[CFG_IRQ];
  assign irq_route_o = cfg[3:0];

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(flag_clr));

  // R10
  pulse_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_act) |-> flag_q);
endmodule

// File: tb/tb_wdt_core.sv
module tb_wdt_core;
  localparam int TPS = 3;
  localparam int SPM = 4;
  localparam int DLY = 5;
  localparam int PL  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] wr_idx_i = '0, wr_data_i = '0;
  logic tick_i = 1'b1;
  logic ir = 1'b0, ms = 1'b0, kb = 1'b0, joy = 1'b0;
  logic expired_o, kbd_rst_o, pwr_fail_o, wdt_irq_o;
  logic [3:0] irq_route_o;

  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_core #(.CNT_W(16), .TICKS_PER_SEC(TPS), .SECS_PER_MIN(SPM),
             .RELOAD_DLY(DLY), .PULSE_LEN(PL)) dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .tick_i,
    .ir_irq_i(ir), .mouse_irq_i(ms), .kbd_irq_i(kb), .joy_rd_i(joy),
    .expired_o, .kbd_rst_o, .pwr_fail_o, .wdt_irq_o, .irq_route_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic set_val(input int v);
    wr(8'h74, v[15:8]);
    wr(8'h73, v[7:0]);
  endtask

  task automatic wait_flag(output int n);
    n = 0;
    while (!expired_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic kick(input int s);
    @(negedge clk);
    case (s)
      0: ir = 1'b1;
      1: ms = 1'b1;
      2: kb = 1'b1;
      default: joy = 1'b1;
    endcase
    @(negedge clk);
    ir = 1'b0; ms = 1'b0; kb = 1'b0; joy = 1'b0;
  endtask

  task automatic hold_clear(input int cycles, input string req);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (expired_o) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  function automatic logic [7:0] en_bit(input int s);
    return 8'h80 >> s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vecs++; errs++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(!expired_o && !kbd_rst_o && !pwr_fail_o && !wdt_irq_o, "R1 outputs",
        int'({expired_o, kbd_rst_o, pwr_fail_o, wdt_irq_o}), 0);
    chk(irq_route_o == 4'h0, "R1 route", int'(irq_route_o), 0);
    hold_clear(50, "R1 idle");

    // R2 foreign indices
    wr(8'h70, 8'h02);
    chk(!expired_o, "R2 force at 0x70", int'(expired_o), 0);
    wr(8'h75, 8'h01);
    hold_clear(30, "R2 value at 0x75");

    // R3 seconds sweep
    wr(8'h72, 8'h80);
    for (int v = 1; v <= 6; v++) begin
      wr(8'h71, 8'h00);
      set_val(v);
      wait_flag(n);
      chk(n == TPS * v, "R3 seconds", n, TPS * v);
    end

    // R12 high byte
    wr(8'h71, 8'h00);
    set_val(257);
    wait_flag(n);
    chk(n == TPS * 257, "R12 16-bit value", n, TPS * 257);

    // R4 minutes sweep
    wr(8'h72, 8'h00);
    for (int v = 1; v <= 3; v++) begin
      wr(8'h71, 8'h00);
      set_val(v);
      wait_flag(n);
      chk(n == TPS * SPM * v, "R4 minutes", n, TPS * SPM * v);
    end

    // R5 zero value
    wr(8'h72, 8'h80);
    wr(8'h71, 8'h00);
    set_val(0);
    hold_clear(200, "R5 zero parked");
    set_val(5);
    repeat (4) @(negedge clk);
    set_val(0);
    hold_clear(100, "R5 zero cancels");

    // R6 enabled sources, R7 disabled sources
    for (int s = 0; s < 4; s++) begin
      wr(8'h71, en_bit(s));
      set_val(4);
      kick(s);
      wait_flag(n);
      chk(n == DLY + TPS * 4, "R6 reload", n, DLY + TPS * 4);

      wr(8'h71, 8'hF0 & ~en_bit(s));
      set_val(4);
      kick(s);
      wait_flag(n);
      chk(n == TPS * 4 - 2, "R7 disabled source", n, TPS * 4 - 2);
    end

    // R8 forced expiry stops counter
    wr(8'h71, 8'h00);
    set_val(200);
    repeat (3) @(negedge clk);
    wr(8'h71, 8'h02);
    chk(expired_o, "R8 force", int'(expired_o), 1);

    // R9 sticky flag
    repeat (20) @(negedge clk);
    chk(expired_o, "R9 holds", int'(expired_o), 1);
    wr(8'h71, 8'h01);
    chk(expired_o, "R9 write one", int'(expired_o), 1);
    wr(8'h71, 8'h00);
    chk(!expired_o, "R9 clear", int'(expired_o), 0);
    hold_clear(650, "R8 counter stopped");

    // R10 routing and pulse length
    wr(8'h72, 8'hF5);
    chk(irq_route_o == 4'h5, "R10 route", int'(irq_route_o), 5);
    set_val(2);
    wait_flag(n);
    chk(kbd_rst_o && pwr_fail_o && wdt_irq_o, "R10 all routed",
        int'({kbd_rst_o, pwr_fail_o, wdt_irq_o}), 7);
    n = 0;
    while (kbd_rst_o && n < 100) begin
      n++;
      @(negedge clk);
    end
    chk(n == PL, "R10 pulse length", n, PL);
    chk(!pwr_fail_o && !wdt_irq_o, "R10 pulse end",
        int'({pwr_fail_o, wdt_irq_o}), 0);

    wr(8'h71, 8'h00);
    wr(8'h72, 8'hC0);
    set_val(3);
    wait_flag(n);
    chk(kbd_rst_o && !pwr_fail_o && !wdt_irq_o, "R10 keyboard only",
        int'({kbd_rst_o, pwr_fail_o, wdt_irq_o}), 4);

    wr(8'h71, 8'h00);
    wr(8'h72, 8'h90);
    set_val(3);
    wait_flag(n);
    chk(!kbd_rst_o && pwr_fail_o && !wdt_irq_o, "R10 power only",
        int'({kbd_rst_o, pwr_fail_o, wdt_irq_o}), 2);

    // R11 test mode
    wr(8'h71, 8'h00);
    wr(8'h72, 8'h80);
    set_val(2);
    wait_flag(n);
    chk(n == TPS * 2, "R11 flag", n, TPS * 2);
    n = 0;
    for (int i = 0; i < PL + 2; i++) begin
      if (kbd_rst_o || pwr_fail_o || wdt_irq_o) n++;
      @(negedge clk);
    end
    chk(n == 0, "R11 no outputs", n, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule